// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a memory-mapped watchdog for a system that must be pulled into reset when software stops servicing it. Software reaches it through a simple 32-bit register port. A write is only honoured when its upper half carries a fixed 16-bit key. Writes without the key, such as stray stores from runaway code, are dropped silently. A prescaler divides an external counter tick by a programmable ratio. Each prescaled step decrements a 16-bit down-counter. When the counter is running and a step arrives with the count already at zero, a sticky bite output is raised. Only a block reset clears it.

Divisor and reload writes are held in shadow registers and have no immediate effect. A refresh register made of three 2-bit groups moves them into use. Each group alternates between the codes 01 and 10, and a swap from one valid code to the other fires that group's action:
- Bits 5:4 copy the divisor shadow into use.
- Bits 3:2 reload the counter from the reload shadow and restart the prescaler.
- Bits 1:0 are stored and read back but trigger nothing here.

Inverting all six bits refreshes everything at once.

The counter is driven by a three-state machine:
- IDLE holds the counter.
- RUN counts.
- EXPIRED is terminal.

Its transitions are:
- IDLE to RUN (start bit set).
- RUN to IDLE (start bit cleared).
- RUN to EXPIRED (step with count zero and no reload in the same cycle).
- EXPIRED holds until reset.

Top module: `keyed_watchdog`

## Requirements
- R1: A write changes a register only when bus_wdata[31:16] equals 0x1234; any other upper half leaves every register and the counter unchanged.
- R2: A read returns, one cycle after bus_re, the stored 16-bit value in bits 15:0 with bits 31:16 zero. The reset values are: configuration 0x0F00, reload 0xFFFF, refresh 0x0015, start 0x0000.
- R3: The register byte offsets are fixed:
  - 0x04 holds the configuration.
  - 0x08 holds the reload value.
  - 0x18 holds the refresh groups.
  - 0x1C holds start.
  - Any other offset reads 0 and ignores writes.
- R4: The configuration field in bits 15:8 holding k divides the tick by k+1. After a counter reload of L while running, the bite rises exactly (L+1)*(k+1) ticks later.
- R5: Configuration and reload writes are read back at once but do not affect counting until the matching refresh group fires.
- R6: A refresh group fires when its code changes 01->10 or 10->01. Bits 5:4 apply the divisor shadow. Bits 3:2 reload the counter from the reload shadow and restart the prescaler. Periodic counter-group toggles keep the bite low.
- R7: Writing a group code of 00 or 11, or the same code it already holds, fires nothing.
- R8: Start bit 0 set lets the counter run; cleared, the counter holds its value and no bite occurs.
- R9: The bite output is sticky: writes of any kind leave it high until rst_n is asserted.
- R10: The prescaler advances only in cycles where cnt_tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Counter tick enable from the slow time base |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data; key in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| wdog_bite | output | 1 | Sticky timeout / reset request |

## Verification
The bench builds the block with its default parameters: a 0x1234 key, a 16-bit counter, an 8-bit divisor field with a reset divide of 16, and a reset reload of 0xFFFF. The divisor and reload are programmable, so short timeouts of 5 to 96 ticks bring exact expiry cycles into reach. Holding cnt_tick high makes every clock a tick. Toggling it exercises the gating. One run refreshes only the counter group, so the reset divide of 16 stays in force, which separates the two refresh groups.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam logic [7:0] OFF_CFG     = 8'h04;
    localparam logic [7:0] OFF_LOAD    = 8'h08;
    localparam logic [7:0] OFF_REFRESH = 8'h18;
    localparam logic [7:0] OFF_START   = 8'h1C;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_e;

    function automatic logic code_flip(input logic [1:0] old_c, input logic [1:0] new_c);
        return (old_c == 2'b01 && new_c == 2'b10) || (old_c == 2'b10 && new_c == 2'b01);
    endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int                  BUS_W      = 32,
    parameter int                  CNT_W      = 16,
    parameter int                  DIV_W      = 8,
    parameter logic [BUS_W/2-1:0]  KEY        = 16'h1234,
    parameter logic [DIV_W-1:0]    DEF_DIV_M1 = 8'd15,
    parameter logic [CNT_W-1:0]    DEF_LOAD   = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             re,
    input  logic [7:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid,
    output logic [DIV_W-1:0] cfg_sh,
    output logic [CNT_W-1:0] load_sh,
    output logic             run_req,
    output logic             cfg_fire,
    output logic             cnt_fire
);
    localparam int HALF    = BUS_W / 2;
    localparam int DIV_LSB = 8;
    localparam int NGRP    = 3;
    localparam int RF_W    = 2 * NGRP;
    localparam logic [RF_W-1:0] RF_INIT = {NGRP{2'b01}};

    logic            key_ok;
    logic [RF_W-1:0] rf_q;
    logic [NGRP-1:1] flip;

    assign key_ok = we && (wdata[BUS_W-1:HALF] == KEY);

    // groups 2 (config) and 1 (counter) carry actions; group 0 is stored only
    for (genvar g = 1; g < NGRP; g++) begin : g_grp
        assign flip[g] = key_ok && (addr == OFF_REFRESH) &&
                         code_flip(rf_q[2*g +: 2], wdata[2*g +: 2]);
    end
    assign cfg_fire = flip[2];
    assign cnt_fire = flip[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sh  <= DEF_DIV_M1;
            load_sh <= DEF_LOAD;
            rf_q    <= RF_INIT;
            run_req <= 1'b0;
        end else if (key_ok) begin
            case (addr)
                OFF_CFG:     cfg_sh  <= wdata[DIV_LSB +: DIV_W];
                OFF_LOAD:    load_sh <= wdata[CNT_W-1:0];
                OFF_REFRESH: rf_q    <= wdata[RF_W-1:0];
                OFF_START:   run_req <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re) begin
                rdata <= '0;
                case (addr)
                    OFF_CFG:     rdata[DIV_LSB +: DIV_W] <= cfg_sh;
                    OFF_LOAD:    rdata[CNT_W-1:0]        <= load_sh;
                    OFF_REFRESH: rdata[RF_W-1:0]         <= rf_q;
                    OFF_START:   rdata[0]                <= run_req;
                    default: ;
                endcase
            end
        end
    end

    p_badkey_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[BUS_W-1:HALF] != KEY) |=>
            ($stable(cfg_sh) && $stable(load_sh) && $stable(run_req) && $stable(rf_q)));

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> rvalid);

    p_read_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rdata[BUS_W-1:HALF] == '0));
endmodule

// File: rtl/kwd_core.sv
module kwd_core
    import kwd_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               DIV_W      = 8,
    parameter logic [DIV_W-1:0] DEF_DIV_M1 = 8'd15,
    parameter logic [CNT_W-1:0] DEF_LOAD   = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_req,
    input  logic             cfg_fire,
    input  logic             cnt_fire,
    input  logic [DIV_W-1:0] cfg_sh,
    input  logic [CNT_W-1:0] load_sh,
    output logic             bite
);
    wd_state_e        st_q, st_n;
    logic [DIV_W-1:0] div_q, pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step = tick && (pre_q >= div_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:    if (run_req) st_n = ST_RUN;
            ST_RUN: begin
                if (!run_req)                                 st_n = ST_IDLE;
                else if (step && cnt_q == '0 && !cnt_fire)    st_n = ST_EXPIRED;
            end
            ST_EXPIRED: st_n = ST_EXPIRED;
            default:    st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bite <= 1'b0;
        else        bite <= (st_n == ST_EXPIRED);
    end

    // prescaler and down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DEF_DIV_M1;
            pre_q <= '0;
            cnt_q <= DEF_LOAD;
        end else begin
            if (cfg_fire) div_q <= cfg_sh;
            if (cnt_fire) begin
                cnt_q <= load_sh;
                pre_q <= '0;
            end else if (st_q == ST_RUN && tick) begin
                if (step) begin
                    pre_q <= '0;
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    p_bite_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> bite);

    p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !cnt_fire) |=> $stable(cnt_q));

    p_expire_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bite) |-> ($past(st_q) == ST_RUN));

    p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_fire) |=> ($stable(pre_q) && $stable(cnt_q)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int               BUS_W      = 32,
    parameter int               CNT_W      = 16,
    parameter int               DIV_W      = 8,
    parameter logic [15:0]      KEY        = 16'h1234,
    parameter logic [DIV_W-1:0] DEF_DIV_M1 = 8'd15,
    parameter logic [CNT_W-1:0] DEF_LOAD   = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [7:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             bus_rvalid,
    output logic             wdog_bite
);
    logic [DIV_W-1:0] cfg_sh;
    logic [CNT_W-1:0] load_sh;
    logic             run_req, cfg_fire, cnt_fire;

    kwd_regs #(
        .BUS_W(BUS_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .KEY(KEY),
        .DEF_DIV_M1(DEF_DIV_M1), .DEF_LOAD(DEF_LOAD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .re(bus_re),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .rvalid(bus_rvalid),
        .cfg_sh(cfg_sh), .load_sh(load_sh), .run_req(run_req),
        .cfg_fire(cfg_fire), .cnt_fire(cnt_fire)
    );

    kwd_core #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .DEF_DIV_M1(DEF_DIV_M1), .DEF_LOAD(DEF_LOAD)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .run_req(run_req),
        .cfg_fire(cfg_fire), .cnt_fire(cnt_fire), .cfg_sh(cfg_sh),
        .load_sh(load_sh), .bite(wdog_bite)
    );
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam logic [15:0] KEY = 16'h1234;
    localparam logic [7:0] A_CFG = 8'h04, A_LOAD = 8'h08, A_RF = 8'h18, A_ST = 8'h1C;

    logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b1;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_rvalid, wdog_bite;
    logic tick_half = 1'b0;

    int checks = 0, errors = 0, cyc = 0, s_edge = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .wdog_bite(wdog_bite)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) cnt_tick <= tick_half ? ~cnt_tick : 1'b1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read", bus_rdata, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [15:0] k = KEY);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = {k, d};
        @(posedge clk); #1;
        s_edge = cyc;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        bus_re = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        @(negedge clk);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        tick_half = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bite_is(input logic e, input string t);
        chk(wdog_bite === e, t, {31'b0, wdog_bite}, {31'b0, e});
    endtask

    int st;
    initial begin
        do_reset();
        bite_is(1'b0, "R2 bite low after reset");
        rd(A_CFG,  32'h0000_0F00, "R2 reset cfg");
        rd(A_LOAD, 32'h0000_FFFF, "R2 reset load");
        rd(A_RF,   32'h0000_0015, "R2 reset refresh");
        rd(A_ST,   32'h0000_0000, "R2 reset start");

        // R1: wrong key ignored
        wr(A_LOAD, 16'h0042, 16'h1235);
        wr(A_ST, 16'h0001, 16'h0000);
        rd(A_LOAD, 32'h0000_FFFF, "R1 bad-key load ignored");
        rd(A_ST,   32'h0000_0000, "R1 bad-key start ignored");
        // R3: unmapped offset
        wr(8'h0C, 16'hBEEF);
        rd(8'h0C, 32'h0, "R3 unmapped offset reads zero");
        rd(A_LOAD, 32'h0000_FFFF, "R3 unmapped write no side effect");

        // R4/R5: k=1, L=3 active, then pending load 200
        wr(A_CFG, 16'h0100);
        wr(A_LOAD, 16'd3);
        rd(A_CFG, 32'h0000_0100, "R5 cfg shadow readback");
        wr(A_RF, 16'h002A);
        wr(A_LOAD, 16'd200);
        rd(A_LOAD, 32'd200, "R5 pending load readback");
        wr(A_ST, 16'h0001);
        st = s_edge;
        wait_cyc(st + 8);  bite_is(1'b0, "R4/R5 no bite before (3+1)*(1+1)");
        wait_cyc(st + 9);  bite_is(1'b1, "R4/R5 bite at (3+1)*(1+1) ticks");
        // R9: sticky
        wr(A_ST, 16'h0000);
        wr(A_RF, 16'h0015);
        wr(A_LOAD, 16'h0000, 16'h0000);
        repeat (5) @(negedge clk);
        bite_is(1'b1, "R9 bite stays high after writes");

        // R6: counter group only, divisor stays 16
        do_reset();
        bite_is(1'b0, "R9 reset clears bite");
        wr(A_CFG, 16'h0000);
        wr(A_LOAD, 16'd5);
        wr(A_RF, 16'h0019);
        wr(A_ST, 16'h0001);
        st = s_edge;
        wait_cyc(st + 96); bite_is(1'b0, "R6 counter group only, no bite before 96");
        wait_cyc(st + 97); bite_is(1'b1, "R6 cfg group unfired, bite at 6*16");

        // R6 keep-alive, R8 stop, R7 ignored codes
        do_reset();
        wr(A_CFG, 16'h0000);
        wr(A_LOAD, 16'd4);
        wr(A_RF, 16'h002A);
        wr(A_ST, 16'h0001);
        for (int i = 0; i < 8; i++) begin
            wr(A_RF, (i % 2 == 0) ? 16'h0026 : 16'h002A);
            @(negedge clk);
        end
        bite_is(1'b0, "R6 periodic counter refresh keeps bite low");
        wr(A_ST, 16'h0000);
        repeat (30) @(negedge clk);
        bite_is(1'b0, "R8 stopped counter never bites");
        wr(A_RF, 16'h0026);
        wr(A_ST, 16'h0001);
        st = s_edge;
        wr(A_RF, 16'h0026);
        wr(A_RF, 16'h002E);
        wait_cyc(st + 5); bite_is(1'b0, "R7 no bite before 5 ticks");
        wait_cyc(st + 6); bite_is(1'b1, "R7 same/invalid codes did not refresh");

        // R10: tick every other cycle
        do_reset();
        wr(A_CFG, 16'h0000);
        wr(A_LOAD, 16'd9);
        wr(A_RF, 16'h002A);
        tick_half = 1'b1;
        wr(A_ST, 16'h0001);
        st = s_edge;
        wait_cyc(st + 18); bite_is(1'b0, "R10 half-rate tick, no bite at 18 cycles");
        wait_cyc(st + 23); bite_is(1'b1, "R10 half-rate tick, bite by 23 cycles");
        tick_half = 1'b0;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule